// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the 16-bit counter that sets the period of a PWM channel. A small write port loads two registers: a control word and a period value. A power-of-two prescaler slows the counter down. The counter then runs in one of four modes: rising, falling, rising-then-falling, or halted.

The block drives the live count and a direction flag. It also drives two single-clock strobes, one when the count lands on zero and one when it lands on the period value. Compare and output-action logic next to this block consume these strobes to build the PWM edges.

The period register has an optional staging copy. When staging is on, a new period waits for the next return to zero, so a running cycle is never cut short or stretched by a write made halfway through it.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the direction flag is 1, both strobes are low, the active period is RESET_PRD (default 0), staging is off, the prescale select is 0 (divide by 1) and the mode is halted (3).
- R2: Control bits [4:2] hold a prescale select k. The counter may change only on prescaler ticks. With k = 0 a tick occurs on every clock; otherwise ticks come once every 2^k clocks.
- R3: Mode 0 (control bits [1:0]) counts up. On each tick the count goes from c to c+1, except that a count at or above the active period P returns to 0. One cycle therefore lasts P+1 ticks. The direction flag reads 1.
- R4: Mode 1 counts down. On each tick the count goes from c to c-1. A count of 0, or a count above P, loads P. The direction flag reads 0.
- R5: Mode 2 counts up to P and then back down to 0. Each end value is held for one tick only. The direction flag is 1 while the count is rising and 0 while it is falling, and it flips on the tick that leaves an end value.
- R6: The zero strobe is high for exactly the one clock in which a tick has just moved the count to 0. The period strobe is high for the one clock in which a tick has just moved the count to the active period.
- R7: Mode 3 holds the count and the direction flag. While the mode is 3 the counter produces no strobes.
- R8: With control bit 5 set, a period write is staged. It becomes active on the same clock edge at which the count next becomes 0.
- R9: With control bit 5 clear, a period write becomes the active period on the clock edge that accepts the write.
- R10: A write with cfg_addr = 0 loads the control word from cfg_wdata[5:0]. A write with cfg_addr = 1 loads the period from cfg_wdata. Either write governs the counter from the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 selects the control word, 1 selects the period |
| cfg_wdata | input | 16 | Write data |
| count_o | output | 16 | Current count |
| dir_up_o | output | 1 | 1 while counting up, 0 while counting down |
| zero_pulse_o | output | 1 | One-clock strobe when the count becomes 0 |
| period_pulse_o | output | 1 | One-clock strobe when the count becomes the period |

## Verification
The prescaler spacing assertion assumes the select field is stable across the two clocks it compares, and it excuses any cycle in which the select has just changed. The bench only rewrites the control word between long runs, so most of each run falls under the check. The staging assertion assumes that only the zero event or an unstaged write may move the active period. The bench therefore writes periods at arbitrary points of the cycle, including counts above the new period, and the assertion must still hold. The halt assertions assume the mode was written at least one clock earlier. The bench spends whole runs in mode 3 after counting.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
  localparam int TB_CNT_W  = 16;
  localparam int TB_PSC_W  = 3;
  localparam int TB_PRE_W  = (1 << TB_PSC_W) - 1;
  localparam int TB_CTRL_W = 2 + TB_PSC_W + 1;

  typedef logic [TB_CNT_W-1:0] tb_cnt_t;

  typedef enum logic [1:0] {
    TB_UP   = 2'd0,
    TB_DOWN = 2'd1,
    TB_UPDN = 2'd2,
    TB_HOLD = 2'd3
  } tb_mode_e;

  typedef struct packed {
    logic                shadow;
    logic [TB_PSC_W-1:0] psel;
    tb_mode_e            mode;
  } tb_ctrl_t;

  typedef struct packed {
    logic    up;
    tb_cnt_t cnt;
  } tb_step_t;

  localparam tb_ctrl_t TB_CTRL_RST = '{shadow: 1'b0, psel: '0, mode: TB_HOLD};

  // Low-bit mask of the prescaler counter that must be all ones for a tick.
  function automatic logic [TB_PRE_W-1:0] psc_mask(input logic [TB_PSC_W-1:0] sel);
    logic [TB_PRE_W:0] weight;
    weight = (TB_PRE_W+1)'(1) << sel;
    return TB_PRE_W'(weight - (TB_PRE_W+1)'(1));
  endfunction

  // One tick of the time base: next count and direction.
  function automatic tb_step_t tb_advance(input tb_mode_e m, input logic up,
                                          input tb_cnt_t c, input tb_cnt_t p);
    tb_step_t s;
    s.up  = up;
    s.cnt = c;
    case (m)
      TB_UP: begin
        s.up  = 1'b1;
        s.cnt = (c >= p) ? '0 : c + TB_CNT_W'(1);
      end
      TB_DOWN: begin
        s.up  = 1'b0;
        s.cnt = (c == '0 || c > p) ? p : c - TB_CNT_W'(1);
      end
      TB_UPDN: begin
        if (up) begin
          if (c >= p) begin
            s.up  = 1'b0;
            s.cnt = (c == '0) ? '0 : c - TB_CNT_W'(1);
          end else begin
            s.cnt = c + TB_CNT_W'(1);
          end
        end else begin
          if (c == '0) begin
            s.up  = 1'b1;
            s.cnt = (p == '0) ? '0 : TB_CNT_W'(1);
          end else begin
            s.cnt = c - TB_CNT_W'(1);
          end
        end
      end
      default: ;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pwmtb_regs.sv
module pwmtb_regs
  import pwmtb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  tb_cnt_t       cfg_wdata,
  output tb_ctrl_t      ctrl_o,
  output logic          prd_wr_o
);
  tb_ctrl_t ctrl_q;
  logic     ctrl_wr;

  assign ctrl_wr  = cfg_we && !cfg_addr;
  assign prd_wr_o = cfg_we && cfg_addr;
  assign ctrl_o   = ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= TB_CTRL_RST;
    else if (ctrl_wr) ctrl_q <= tb_ctrl_t'(cfg_wdata[TB_CTRL_W-1:0]);
  end

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q == tb_ctrl_t'($past(cfg_wdata[TB_CTRL_W-1:0]))); // R10
endmodule

// File: rtl/pwmtb_prescale.sv
module pwmtb_prescale
  import pwmtb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TB_PSC_W-1:0] psel,
  output logic                tick_o
);
  logic [TB_PRE_W-1:0] pre_q;
  logic [TB_PRE_W-1:0] mask;

  assign mask   = psc_mask(psel);
  assign tick_o = (pre_q & mask) == mask;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + TB_PRE_W'(1);
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && psel != '0) |=> (!tick_o || psel != $past(psel))); // R2
endmodule

// File: rtl/pwmtb_period.sv
module pwmtb_period
  import pwmtb_pkg::*;
#(
  parameter tb_cnt_t RESET_PRD = '0
)(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    prd_wr,
  input  tb_cnt_t wdata,
  input  logic    shadow_en,
  input  logic    zero_evt,
  output tb_cnt_t prd_q_o,
  output tb_cnt_t prd_nxt_o
);
  tb_cnt_t prd_q, shd_q, prd_nxt;
  logic    pend_q;
  logic    stage_load;
  logic    direct_wr;

  assign stage_load = pend_q && zero_evt;
  assign direct_wr  = prd_wr && !shadow_en;

  always_comb begin
    prd_nxt = prd_q;
    if (stage_load) prd_nxt = shd_q;
    if (direct_wr)  prd_nxt = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_q  <= RESET_PRD;
      shd_q  <= RESET_PRD;
      pend_q <= 1'b0;
    end else begin
      prd_q <= prd_nxt;
      if (prd_wr && shadow_en) shd_q <= wdata;
      if (prd_wr)              pend_q <= shadow_en;
      else if (stage_load)     pend_q <= 1'b0;
    end
  end

  assign prd_q_o   = prd_q;
  assign prd_nxt_o = prd_nxt;

  AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_evt && !direct_wr) |=> $stable(prd_q)); // R8
  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    direct_wr |=> prd_q == $past(wdata)); // R9
endmodule

// File: rtl/pwmtb_core.sv
module pwmtb_core
  import pwmtb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  tb_mode_e mode,
  input  tb_cnt_t  prd_q,
  input  tb_cnt_t  prd_nxt,
  output logic     zero_evt_o,
  output tb_cnt_t  cnt_o,
  output logic     dir_o,
  output logic     zero_pulse_o,
  output logic     prd_pulse_o
);
  tb_cnt_t  cnt_q;
  logic     dir_q, zp_q, pp_q;
  logic     run;
  tb_step_t step;
  logic     prd_evt;

  assign run        = tick && (mode != TB_HOLD);
  assign step       = tb_advance(mode, dir_q, cnt_q, prd_q);
  assign zero_evt_o = run && (step.cnt == '0);
  assign prd_evt    = run && (step.cnt == prd_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
      zp_q  <= 1'b0;
      pp_q  <= 1'b0;
    end else begin
      zp_q <= zero_evt_o;
      pp_q <= prd_evt;
      if (run) begin
        cnt_q <= step.cnt;
        dir_q <= step.up;
      end
    end
  end

  assign cnt_o        = cnt_q;
  assign dir_o        = dir_q;
  assign zero_pulse_o = zp_q;
  assign prd_pulse_o  = pp_q;

  AST_ZERO_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zp_q |-> cnt_q == '0); // R6
  AST_PRD_AT_PRD: assert property (@(posedge clk) disable iff (!rst_n)
    pp_q |-> cnt_q == prd_q); // R6
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TB_HOLD) |=> ($stable(cnt_q) && $stable(dir_q))); // R7
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TB_HOLD) |=> (!zp_q && !pp_q)); // R7
  AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R2
  AST_UP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == TB_UP) |=> dir_q); // R3
  AST_DOWN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == TB_DOWN) |=> !dir_q); // R4
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwmtb_pkg::*;
#(
  parameter tb_cnt_t RESET_PRD = '0
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_addr,
  input  logic [TB_CNT_W-1:0] cfg_wdata,
  output logic [TB_CNT_W-1:0] count_o,
  output logic                dir_up_o,
  output logic                zero_pulse_o,
  output logic                period_pulse_o
);
  tb_ctrl_t ctrl;
  logic     prd_wr;
  logic     tick;
  logic     zero_evt;
  tb_cnt_t  prd_q, prd_nxt;

  pwmtb_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ctrl_o    (ctrl),
    .prd_wr_o  (prd_wr)
  );

  pwmtb_prescale u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .psel   (ctrl.psel),
    .tick_o (tick)
  );

  pwmtb_period #(.RESET_PRD(RESET_PRD)) u_prd (
    .clk       (clk),
    .rst_n     (rst_n),
    .prd_wr    (prd_wr),
    .wdata     (cfg_wdata),
    .shadow_en (ctrl.shadow),
    .zero_evt  (zero_evt),
    .prd_q_o   (prd_q),
    .prd_nxt_o (prd_nxt)
  );

  pwmtb_core u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .mode         (ctrl.mode),
    .prd_q        (prd_q),
    .prd_nxt      (prd_nxt),
    .zero_evt_o   (zero_evt),
    .cnt_o        (count_o),
    .dir_o        (dir_up_o),
    .zero_pulse_o (zero_pulse_o),
    .prd_pulse_o  (period_pulse_o)
  );
endmodule

// File: tb/sim_pwm_timebase.sv
`timescale 1ns/1ps
module sim_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] count_o;
  logic        dir_up_o, zero_pulse_o, period_pulse_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;
  string tag = "R1";

  // reference model state
  int m_mode, m_ps, m_sh, m_prd, m_shd, m_pend, m_cnt, m_dir, m_pre, m_z, m_p;

  always #10 clk = ~clk;

  pwm_timebase u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .count_o(count_o), .dir_up_o(dir_up_o),
    .zero_pulse_o(zero_pulse_o), .period_pulse_o(period_pulse_o)
  );

  always @(posedge clk) begin
    int nc, nd, tk, run, zev;
    if (!rst_n) begin
      m_mode = 3; m_ps = 0; m_sh = 0; m_prd = 0; m_shd = 0; m_pend = 0;
      m_cnt = 0; m_dir = 1; m_pre = 0; m_z = 0; m_p = 0;
    end else begin
      tk = ((m_pre % (1 << m_ps)) == ((1 << m_ps) - 1)) ? 1 : 0;
      m_pre = (m_pre + 1) % 128;
      run = (tk == 1 && m_mode != 3) ? 1 : 0;
      nc = m_cnt; nd = m_dir;
      if (run == 1) begin
        if (m_mode == 0) begin
          nd = 1;
          nc = (m_cnt >= m_prd) ? 0 : m_cnt + 1;
        end else if (m_mode == 1) begin
          nd = 0;
          nc = (m_cnt == 0 || m_cnt > m_prd) ? m_prd : m_cnt - 1;
        end else begin
          if (m_dir == 1 && m_cnt >= m_prd) begin
            nd = 0; nc = (m_cnt == 0) ? 0 : m_cnt - 1;
          end else if (m_dir == 1) begin
            nc = m_cnt + 1;
          end else if (m_cnt == 0) begin
            nd = 1; nc = (m_prd == 0) ? 0 : 1;
          end else begin
            nc = m_cnt - 1;
          end
        end
      end
      zev = (run == 1 && nc == 0) ? 1 : 0;
      if (m_pend == 1 && zev == 1) begin m_prd = m_shd; m_pend = 0; end
      if (cfg_we && cfg_addr) begin
        if (m_sh == 1) begin m_shd = cfg_wdata; m_pend = 1; end
        else begin m_prd = cfg_wdata; m_pend = 0; end
      end
      if (cfg_we && !cfg_addr) begin
        m_mode = cfg_wdata[1:0]; m_ps = cfg_wdata[4:2]; m_sh = cfg_wdata[5];
      end
      m_z = zev;
      m_p = (run == 1 && nc == m_prd) ? 1 : 0;
      if (run == 1) begin m_cnt = nc; m_dir = nd; end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (count_o != m_cnt[15:0] || dir_up_o != m_dir[0]) begin
        errors++;
        $display("FAIL %s count/dir actual %0d/%0d expected %0d/%0d", tag,
                 count_o, dir_up_o, m_cnt, m_dir);
      end
      checks++;
      if (zero_pulse_o != m_z[0] || period_pulse_o != m_p[0]) begin
        errors++;
        $display("FAIL R6 strobes zero/period actual %0d/%0d expected %0d/%0d",
                 zero_pulse_o, period_pulse_o, m_z, m_p);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R10 watchdog actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R10: one-clock write strobe, address 0 = control, 1 = period
  task automatic wr(input bit a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d[15:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int ctl(input int mode, input int ps, input int sh);
    return mode | (ps << 2) | (sh << 5);
  endfunction

  task automatic expect_eq(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  initial begin
    int c0, gap;
    idle(4);
    rst_n = 1'b1;
    // R1: reset state seen right after release
    expect_eq("R1 count", count_o, 0);
    expect_eq("R1 dir", dir_up_o, 1);
    expect_eq("R1 strobes", zero_pulse_o | period_pulse_o, 0);
    cmp_on = 1'b1;
    tag = "R1 R7"; idle(10);
    expect_eq("R1 halted count", count_o, 0);

    tag = "R10 R9"; wr(1'b1, 5);
    tag = "R3"; wr(1'b0, ctl(0, 0, 0)); idle(30);

    // R2: select 2 -> one step every 4 clocks
    tag = "R2"; wr(1'b1, 20); wr(1'b0, ctl(0, 2, 0)); idle(12);
    c0 = count_o;
    while (count_o == c0) @(negedge clk);
    c0 = count_o; gap = 0;
    while (count_o == c0) begin @(negedge clk); gap++; end
    expect_eq("R2 tick spacing", gap, 4);
    idle(60);

    // R3: period lowered below the running count
    tag = "R3 R9"; wr(1'b1, 40); wr(1'b0, ctl(0, 0, 0));
    while (count_o != 25) @(negedge clk);
    wr(1'b1, 10); idle(30);

    tag = "R4 R10"; wr(1'b0, ctl(1, 0, 0)); idle(40);
    tag = "R4"; wr(1'b1, 30);
    while (count_o != 3) @(negedge clk);
    wr(1'b1, 40);
    while (count_o != 35) @(negedge clk);
    wr(1'b1, 8); idle(30);

    tag = "R5"; wr(1'b1, 4); wr(1'b0, ctl(2, 0, 0)); idle(40);
    tag = "R5 R2"; wr(1'b0, ctl(2, 1, 0)); idle(40);

    // R7: halted count does not move
    tag = "R7"; wr(1'b0, ctl(3, 0, 0)); c0 = count_o; idle(15);
    expect_eq("R7 held count", count_o, c0);

    // R8: staged period waits for zero
    tag = "R8"; wr(1'b1, 6); wr(1'b0, ctl(0, 0, 1)); idle(5);
    wr(1'b1, 12); idle(40);
    wr(1'b1, 3); idle(30);
    tag = "R8 R5"; wr(1'b0, ctl(2, 0, 1)); wr(1'b1, 9); idle(50);

    tag = "R6"; wr(1'b1, 0); wr(1'b0, ctl(0, 0, 0)); idle(10);
    tag = "R6 R4"; wr(1'b0, ctl(1, 3, 0)); wr(1'b1, 2); idle(60);

    // R9: direct write visible on next strobe
    tag = "R9"; wr(1'b0, ctl(0, 0, 0)); wr(1'b1, 7); idle(20);

    cmp_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule